// File: doc/BRIEF.md
# Three-Slot Frame Buffer Controller

This block lets a video stream be written into external memory in one clock domain and read back in another, unrelated clock domain without the reader ever seeing a half-written picture. Memory holds three frame slots. The writer fills one slot. The most recently finished slot is published as the newest frame. The reader keeps whichever slot it latched at its own frame start. Because three slots exist, the writer always has a slot free that is neither the one the reader holds nor the one just published.

On the write side the block takes a pixel stream with a frame-start strobe and a valid flag. It packs the pixels into fixed-length bursts and presents each burst, with its memory address, on a request/acknowledge port that stands in for the memory controller. The address of a burst is the slot base (slot index times a programmable frame stride), plus the line number times a programmable line stride, plus the burst position within the line. On the read side, a frame-start strobe makes the block latch the newest complete slot and present that slot's base address. The slot indices cross between the two clocks as Gray-coded 2-bit values. Each crossing uses a two-flop synchronizer followed by an agreement filter. The nominal use is 1920x1080 video at 60 frames per second.

Top module: `tribuf_ctrl`

## Requirements
- R1: After reset `bw_req` and `rd_valid` are 0. A `rd_sof` pulse before the first written frame has been closed by a later `wr_sof` leaves `rd_valid` at 0.
- R2: The first frame after reset is written into slot 0, so its first burst address is 0.
- R3: A burst request is raised only when BURST_LEN pixels of the current frame have been collected. `bw_data` carries the first pixel of the burst in bits [PIX_W-1:0] and pixel k in bits [k*PIX_W +: PIX_W]. The acknowledge for a burst must arrive before the next burst is complete.
- R4: A burst address equals slot*cfg_frame_stride + line*cfg_line_stride + col*BURST_LEN*BPP. `col` counts bursts within a line. After `cfg_line_bursts` bursts, `col` returns to 0 and `line` increments. Both `line` and `col` restart at 0 on each frame start.
- R5: `bw_req` stays high with a stable `bw_addr` until `bw_ack`. It is low in the cycle after the acknowledge.
- R6: A `wr_sof` that follows an earlier frame publishes the slot just written as the newest frame. The writer then moves to slot (cur+1) mod 3.
- R7: On `rd_sof`, if a frame has been published, the reader latches the newest slot, drives `rd_valid`=1, `rd_slot` and `rd_base` = slot*cfg_frame_stride, and holds them unchanged until the next `rd_sof`.
- R8: If no new frame was published since the last `rd_sof`, the next `rd_sof` keeps the same slot and base (the frame repeats).
- R9: If slot (cur+1) mod 3 is the one the reader holds, the writer takes (cur+2) mod 3 instead. It never writes the held slot.
- R10: Pixels of a burst left incomplete when `wr_sof` arrives are discarded. The new frame's first burst holds only new-frame pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| wrst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_sof | input | 1 | Frame start; a pixel valid in the same cycle is the frame's first pixel |
| wr_valid | input | 1 | Pixel valid |
| wr_pix | input | PIX_W | Pixel data |
| bw_req | output | 1 | Burst write request |
| bw_addr | output | ADDR_W | Burst byte address |
| bw_data | output | BURST_LEN*PIX_W | Burst pixels, first pixel lowest |
| bw_ack | input | 1 | Burst accepted (one-cycle pulse while `bw_req` is high) |
| rclk | input | 1 | Read-domain clock |
| rrst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_sof | input | 1 | Reader frame start |
| rd_valid | output | 1 | A complete frame is selected |
| rd_slot | output | 2 | Slot being read (3 = none) |
| rd_base | output | ADDR_W | Base address of the slot being read |
| cfg_frame_stride | input | ADDR_W | Byte distance between slots (quasi-static) |
| cfg_line_stride | input | ADDR_W | Byte distance between lines (quasi-static) |
| cfg_line_bursts | input | COL_W | Bursts per line (quasi-static, nonzero) |

## Verification
The hardest case to reach is the writer skipping the slot the reader holds. To reach it, the reader must latch a slot and that hold must cross back to the write clock before the writer's next frame start. The writer must also be exactly one slot behind the held one. The bench produces this with a fixed sequence. It writes two frames, latches the first one on the read side, and waits for the synchronizers. It then writes two short frames, so that the writer's rotation lands on the held slot. It checks that the address jumps past that slot. A second case closes a frame while a burst is half collected and confirms that those pixels never appear in memory.

// File: rtl/tribuf_pkg.sv
package tribuf_pkg;
  localparam logic [1:0] SLOT_NONE = 2'd3;

  function automatic logic [1:0] to_gray(input logic [1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [1:0] from_gray(input logic [1:0] g);
    return {g[1], g[1] ^ g[0]};
  endfunction

  // next slot after cur that is not the reader-held one
  function automatic logic [1:0] pick_slot(input logic [1:0] cur, input logic [1:0] held);
    logic [1:0] n1, n2;
    n1 = (cur == 2'd2) ? 2'd0 : cur + 2'd1;
    n2 = (n1 == 2'd2) ? 2'd0 : n1 + 2'd1;
    return (n1 == held) ? n2 : n1;
  endfunction
endpackage

// File: rtl/tribuf_sync.sv
module tribuf_sync #(
  parameter logic [1:0] RST_G = 2'b10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] d_gray,
  output logic [1:0] q_bin
);
  import tribuf_pkg::*;
  logic [1:0] s1, s2;

  // two flops, then accept only when both stages agree
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= RST_G;
      s2    <= RST_G;
      q_bin <= from_gray(RST_G);
    end else begin
      s1 <= d_gray;
      s2 <= s1;
      if (s1 == s2) q_bin <= from_gray(s2);
    end
  end
endmodule

// File: rtl/tribuf_wr.sv
module tribuf_wr #(
  parameter int PIX_W     = 24,
  parameter int BURST_LEN = 8,
  parameter int BPP       = 4,
  parameter int ADDR_W    = 32,
  parameter int LINE_W    = 12,
  parameter int COL_W     = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sof,
  input  logic                       valid,
  input  logic [PIX_W-1:0]           pix,
  input  logic [ADDR_W-1:0]          frame_stride,
  input  logic [ADDR_W-1:0]          line_stride,
  input  logic [COL_W-1:0]           line_bursts,
  input  logic [1:0]                 rhold,
  output logic [1:0]                 latest_g,
  output logic                       bw_req,
  output logic [ADDR_W-1:0]          bw_addr,
  output logic [BURST_LEN*PIX_W-1:0] bw_data,
  input  logic                       bw_ack
);
  import tribuf_pkg::*;
  localparam int FILL_W      = $clog2(BURST_LEN);
  localparam int BURST_BYTES = BURST_LEN * BPP;

  function automatic logic [ADDR_W-1:0] burst_addr(
    input logic [1:0] slot, input logic [LINE_W-1:0] line, input logic [COL_W-1:0] col);
    return ADDR_W'(slot) * frame_stride + ADDR_W'(line) * line_stride
         + ADDR_W'(col) * ADDR_W'(BURST_BYTES);
  endfunction

  logic [1:0]        cur_slot, latest_w;
  logic              started;
  logic [FILL_W-1:0] fill, fill_eff;
  logic [LINE_W-1:0] line, line_eff;
  logic [COL_W-1:0]  col, col_eff;
  logic [1:0]        slot_eff;
  logic [BURST_LEN-1:0][PIX_W-1:0] coll, coll_next;

  // named events
  logic frame_done, burst_done, take_pix, line_end;

  assign frame_done = sof && started;
  assign take_pix   = valid && (started || sof);
  assign fill_eff   = sof ? '0 : fill;
  assign line_eff   = sof ? '0 : line;
  assign col_eff    = sof ? '0 : col;
  assign slot_eff   = frame_done ? pick_slot(cur_slot, rhold) : cur_slot;
  assign burst_done = take_pix && (fill_eff == FILL_W'(BURST_LEN - 1));
  assign line_end   = (col_eff == line_bursts - COL_W'(1));

  always_comb begin
    coll_next = coll;
    coll_next[fill_eff] = pix;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_slot <= 2'd0;
      latest_w <= SLOT_NONE;
      latest_g <= to_gray(SLOT_NONE);
      started  <= 1'b0;
    end else if (sof) begin
      started <= 1'b1;
      if (frame_done) begin
        latest_w <= cur_slot;
        latest_g <= to_gray(cur_slot);
        cur_slot <= slot_eff;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
      line <= '0;
      col  <= '0;
      coll <= '0;
    end else begin
      if (take_pix) begin
        coll <= coll_next;
        fill <= burst_done ? '0 : fill_eff + FILL_W'(1);
      end else if (sof) begin
        fill <= '0;
      end
      if (burst_done) begin
        col  <= line_end ? '0 : col_eff + COL_W'(1);
        line <= line_end ? line_eff + LINE_W'(1) : line_eff;
      end else if (sof) begin
        col  <= '0;
        line <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bw_req  <= 1'b0;
      bw_addr <= '0;
      bw_data <= '0;
    end else if (burst_done) begin
      bw_req  <= 1'b1;
      bw_addr <= burst_addr(slot_eff, line_eff, col_eff);
      bw_data <= coll_next;
    end else if (bw_ack) begin
      bw_req <= 1'b0;
    end
  end

  assert_skip_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> cur_slot != $past(rhold));
  assert_publish_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (latest_w != cur_slot) && (cur_slot != SLOT_NONE));
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bw_req && !bw_ack && !burst_done) |=> bw_req && $stable(bw_addr));
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> (!bw_req || bw_ack));
endmodule

// File: rtl/tribuf_rd.sv
module tribuf_rd #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_sof,
  input  logic [1:0]        latest,
  input  logic [ADDR_W-1:0] frame_stride,
  output logic              rd_valid,
  output logic [1:0]        rd_slot,
  output logic [ADDR_W-1:0] rd_base,
  output logic [1:0]        held_g
);
  import tribuf_pkg::*;
  logic take_frame;
  assign take_frame = rd_sof && (latest != SLOT_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_slot  <= SLOT_NONE;
      rd_base  <= '0;
      held_g   <= to_gray(SLOT_NONE);
    end else if (take_frame) begin
      rd_valid <= 1'b1;
      rd_slot  <= latest;
      rd_base  <= ADDR_W'(latest) * frame_stride;
      held_g   <= to_gray(latest);
    end
  end

  assert_valid_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_slot != SLOT_NONE);
  assert_hold_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sof |=> $stable(rd_slot) && $stable(rd_base) && $stable(rd_valid));
endmodule

// File: rtl/tribuf_ctrl.sv
module tribuf_ctrl #(
  parameter int PIX_W     = 24,
  parameter int BURST_LEN = 8,
  parameter int BPP       = 4,
  parameter int ADDR_W    = 32,
  parameter int LINE_W    = 12,
  parameter int COL_W     = 10
) (
  input  logic                       wclk,
  input  logic                       wrst_n,
  input  logic                       wr_sof,
  input  logic                       wr_valid,
  input  logic [PIX_W-1:0]           wr_pix,
  output logic                       bw_req,
  output logic [ADDR_W-1:0]          bw_addr,
  output logic [BURST_LEN*PIX_W-1:0] bw_data,
  input  logic                       bw_ack,
  input  logic                       rclk,
  input  logic                       rrst_n,
  input  logic                       rd_sof,
  output logic                       rd_valid,
  output logic [1:0]                 rd_slot,
  output logic [ADDR_W-1:0]          rd_base,
  input  logic [ADDR_W-1:0]          cfg_frame_stride,
  input  logic [ADDR_W-1:0]          cfg_line_stride,
  input  logic [COL_W-1:0]           cfg_line_bursts
);
  import tribuf_pkg::*;
  localparam logic [1:0] NONE_G = 2'b10; // Gray code of SLOT_NONE

  logic [1:0] latest_g_w, latest_r, held_g_r, held_w;

  tribuf_wr #(.PIX_W(PIX_W), .BURST_LEN(BURST_LEN), .BPP(BPP), .ADDR_W(ADDR_W),
              .LINE_W(LINE_W), .COL_W(COL_W)) u_wr (
    .clk(wclk), .rst_n(wrst_n), .sof(wr_sof), .valid(wr_valid), .pix(wr_pix),
    .frame_stride(cfg_frame_stride), .line_stride(cfg_line_stride),
    .line_bursts(cfg_line_bursts), .rhold(held_w), .latest_g(latest_g_w),
    .bw_req(bw_req), .bw_addr(bw_addr), .bw_data(bw_data), .bw_ack(bw_ack));

  tribuf_sync #(.RST_G(NONE_G)) u_sync_latest (
    .clk(rclk), .rst_n(rrst_n), .d_gray(latest_g_w), .q_bin(latest_r));

  tribuf_rd #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rclk), .rst_n(rrst_n), .rd_sof(rd_sof), .latest(latest_r),
    .frame_stride(cfg_frame_stride), .rd_valid(rd_valid), .rd_slot(rd_slot),
    .rd_base(rd_base), .held_g(held_g_r));

  tribuf_sync #(.RST_G(NONE_G)) u_sync_held (
    .clk(wclk), .rst_n(wrst_n), .d_gray(held_g_r), .q_bin(held_w));
endmodule

// File: tb/tribuf_ctrl_bench.sv
`timescale 1ns/1ps
module tribuf_ctrl_bench;
  localparam int PIX_W = 24, BL = 8, BPP = 4, AW = 32, CW = 10;
  localparam int DW = BL * PIX_W;
  localparam logic [AW-1:0] FS = 32'h10000, LS = 32'h100;

  logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
  logic wr_sof = 0, wr_valid = 0, bw_ack = 0, rd_sof = 0;
  logic [PIX_W-1:0] wr_pix = '0;
  logic bw_req, rd_valid;
  logic [AW-1:0] bw_addr, rd_base;
  logic [DW-1:0] bw_data;
  logic [1:0] rd_slot;

  always #10 wclk = ~wclk;   // 50 MHz
  always #13 rclk = ~rclk;   // unrelated read clock

  tribuf_ctrl #(.PIX_W(PIX_W), .BURST_LEN(BL), .BPP(BPP), .ADDR_W(AW), .COL_W(CW)) u_tribuf_ctrl (
    .wclk(wclk), .wrst_n(wrst_n), .wr_sof(wr_sof), .wr_valid(wr_valid), .wr_pix(wr_pix),
    .bw_req(bw_req), .bw_addr(bw_addr), .bw_data(bw_data), .bw_ack(bw_ack),
    .rclk(rclk), .rrst_n(rrst_n), .rd_sof(rd_sof), .rd_valid(rd_valid), .rd_slot(rd_slot),
    .rd_base(rd_base), .cfg_frame_stride(FS), .cfg_line_stride(LS),
    .cfg_line_bursts(CW'(2)));

  int checks = 0, errors = 0, n_log = 0;
  logic [AW-1:0] log_addr [64];
  logic [DW-1:0] log_data [64];
  bit ack_en = 1, man_go = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory stand-in: accepts one burst per request
  initial forever begin
    @(negedge wclk);
    if (bw_ack) bw_ack = 0;
    else if (bw_req && (ack_en || man_go)) begin
      if (n_log < 64) begin
        log_addr[n_log] = bw_addr;
        log_data[n_log] = bw_data;
      end
      n_log++;
      bw_ack = 1;
    end
  end

  function automatic logic [PIX_W-1:0] pxv(input int fid, input int idx);
    return {8'(fid), 16'(idx)};
  endfunction

  function automatic logic [DW-1:0] exp_burst(input int fid, input int b);
    logic [DW-1:0] d;
    for (int k = 0; k < BL; k++) d[k*PIX_W +: PIX_W] = pxv(fid, b * BL + k);
    return d;
  endfunction

  task automatic drive_px(input int fid, input int n, input bit with_sof);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_sof = with_sof && (i == 0);
      wr_valid = 1;
      wr_pix = pxv(fid, i);
    end
    @(negedge wclk);
    wr_sof = 0; wr_valid = 0;
    repeat (6) @(negedge wclk);
  endtask

  task automatic pulse_rd;
    @(negedge rclk); rd_sof = 1;
    @(negedge rclk); rd_sof = 0;
    @(negedge rclk);
  endtask

  task automatic settle;
    repeat (10) @(negedge rclk);
    repeat (10) @(negedge wclk);
  endtask

  task automatic t_reset;
    chk(bw_req == 0, "R1 bw_req after reset", 64'(bw_req), 0);
    chk(rd_valid == 0, "R1 rd_valid after reset", 64'(rd_valid), 0);
    pulse_rd();
    chk(rd_valid == 0, "R1 rd_valid with no frame", 64'(rd_valid), 0);
  endtask

  task automatic t_first_frame;
    int base = n_log;
    drive_px(1, 48, 1);
    chk(n_log - base == 6, "R3 burst count for 48 pixels", 64'(n_log - base), 6);
    for (int b = 0; b < 6; b++) begin
      logic [AW-1:0] ea = AW'(b / 2) * LS + AW'(b % 2) * AW'(BL * BPP);
      chk(log_addr[base + b] == ea, (b == 0) ? "R2 slot0 first address" : "R4 line/col address",
          64'(log_addr[base + b]), 64'(ea));
      chk(log_data[base + b] == exp_burst(1, b), "R3 burst packing",
          64'(log_data[base + b]), 64'(exp_burst(1, b)));
    end
    settle();
    pulse_rd();
    chk(rd_valid == 0, "R1 no read before frame closed", 64'(rd_valid), 0);
  endtask

  task automatic t_publish;
    int base = n_log;
    drive_px(2, 48, 1);
    chk(log_addr[base] == FS, "R6 rotate to slot1", 64'(log_addr[base]), 64'(FS));
    settle();
    pulse_rd();
    chk(rd_valid == 1 && rd_slot == 0, "R7 reader latches slot0", 64'({rd_valid, rd_slot}), 64'({1'b1, 2'd0}));
    chk(rd_base == 0, "R7 reader base slot0", 64'(rd_base), 0);
    settle();
  endtask

  task automatic t_skip_held;
    int base = n_log;
    drive_px(3, 16, 1);
    chk(log_addr[base] == 2 * FS, "R6 rotate to slot2", 64'(log_addr[base]), 64'(2 * FS));
    drive_px(4, 16, 1);
    chk(log_addr[base + 2] == FS, "R9 skip held slot0", 64'(log_addr[base + 2]), 64'(FS));
    chk(log_addr[base + 3] == FS + AW'(BL * BPP), "R4 second column", 64'(log_addr[base + 3]),
        64'(FS + AW'(BL * BPP)));
    settle();
  endtask

  task automatic t_repeat;
    logic [AW-1:0] b0;
    pulse_rd();
    chk(rd_slot == 2 && rd_base == 2 * FS, "R7 reader latches slot2", 64'(rd_base), 64'(2 * FS));
    b0 = rd_base;
    repeat (20) @(negedge rclk);
    chk(rd_base == b0 && rd_slot == 2, "R7 hold between frame starts", 64'(rd_base), 64'(b0));
    pulse_rd();
    chk(rd_slot == 2 && rd_base == b0 && rd_valid, "R8 repeat frame", 64'(rd_slot), 2);
    settle();
  endtask

  task automatic t_hold_req;
    int base = n_log;
    ack_en = 0;
    drive_px(5, 8, 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge wclk);
      chk(bw_req == 1 && bw_addr == 0, "R5 request held (R9 slot0)", 64'(bw_addr), 0);
    end
    man_go = 1;
    while (!bw_ack) @(negedge wclk);
    man_go = 0;
    @(negedge wclk);
    chk(bw_req == 0, "R5 request dropped after ack", 64'(bw_req), 0);
    chk(n_log - base == 1, "R5 single burst accepted", 64'(n_log - base), 1);
    ack_en = 1;
    settle();
  endtask

  task automatic t_partial;
    int base = n_log;
    drive_px(6, 5, 1);
    chk(n_log == base, "R3 no burst for 5 pixels", 64'(n_log - base), 0);
    drive_px(7, 8, 1);
    chk(n_log - base == 1, "R10 one burst after frame start", 64'(n_log - base), 1);
    chk(log_data[base] == exp_burst(7, 0), "R10 stale pixels discarded",
        64'(log_data[base]), 64'(exp_burst(7, 0)));
    chk(log_addr[base] == 0, "R9 partial frame slot choice", 64'(log_addr[base]), 0);
    settle();
    pulse_rd();
    chk(rd_slot == 1 && rd_base == FS, "R6 partial frame published", 64'(rd_base), 64'(FS));
  endtask

  initial begin
    repeat (3) @(negedge wclk);
    wrst_n = 1; rrst_n = 1;
    repeat (3) @(negedge wclk);
    t_reset();
    t_first_frame();
    t_publish();
    t_skip_held();
    t_repeat();
    t_hold_req();
    t_partial();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wclk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule